// File: doc/BRIEF.md
# Group-0 End-of-Interrupt Write Access Router

This block decides what happens when software writes the group-0 end-of-interrupt system register. A request carries the system-register encoding and the exception level of the writer. The block compares the encoding against the one register it serves. It then walks a fixed, level-specific chain of checks over a set of control bits. These bits describe which higher levels are implemented and enabled, the system-register-enable bit of each level, and the interrupt routing controls of the hypervisor and the secure monitor.

The verdict is registered and appears one cycle after the request, marked by a single-cycle valid pulse. It takes one of four forms: an undefined-instruction exception, a trap to a higher level, a redirect to the virtual interface, or a plain physical register write. A trap also reports its target level and a fixed syndrome class. Carrying out the exception and holding the register contents are left to neighbouring logic.

Top module: `sreg_trap_router`

## Requirements
- R1: A matching request from level 0 always yields UNDEF.
- R2: At level 1 the checks apply in this order, and the first one that applies decides the verdict. First, if level 3 is implemented, its early-undefined condition holds and its interrupt routing bit is set, the verdict is UNDEF. Next, if the level-1 enable bit is 0, the verdict is a trap to level 1. Next, if level 2 is on and the hypervisor trap-all bit is 1, the verdict is a trap to level 2. Next, if level 2 is on and the hypervisor routing bit is 1, the verdict is VIRTUAL. Next, if level 3 is implemented with its routing bit set, the verdict is UNDEF when its late-undefined condition holds and a trap to level 3 otherwise. Failing all of these, the verdict is PHYSICAL.
- R3: Level 2 counts as on only when both level-2-implemented and the level-2 security enable are 1. When level 2 is off, both hypervisor checks of R2 are skipped.
- R4: At level 2 the checks apply in this order. The early-undefined check of R2 gives UNDEF. Next, if the level-2 enable bit is 0, the verdict is a trap to level 2. Next, the level-3 routing check of R2 gives UNDEF or a trap to level 3. Failing these, the verdict is PHYSICAL. The hypervisor bits have no effect at this level.
- R5: At level 3, if the level-3 enable bit is 0 the verdict is a trap to level 3; otherwise it is PHYSICAL.
- R6: A trap reports syndrome class 0x18 on rsp_class and its target level (1, 2 or 3) on rsp_tgt_lvl. Any other verdict drives both fields to 0.
- R7: Only the encoding op0=2'b11, op1=3'b000, CRn=4'b1100, CRm=4'b1000, op2=3'b001 is served. A request with any other encoding produces no rsp_valid pulse.
- R8: A request sampled at a rising clock edge produces rsp_valid high for the following cycle only, unless another request is sampled at that edge.
- R9: While rst_n is low at a clock edge, rsp_valid, rsp_outcome, rsp_tgt_lvl and rsp_class are cleared to 0.
- R10: rsp_outcome is one-hot whenever rsp_valid is high. Bit 0 means UNDEF, bit 1 TRAP, bit 2 VIRTUAL and bit 3 PHYSICAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request strobe |
| req_lvl | input | 2 | Exception level of the writer |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| l2_impl | input | 1 | Level 2 implemented |
| l2_sec_en | input | 1 | Level 2 enabled in current security state |
| l3_impl | input | 1 | Level 3 implemented |
| l3_undef_early | input | 1 | Level-3 early-undefined condition |
| l3_undef_late | input | 1 | Level-3 late-undefined condition |
| l3_fiq_route | input | 1 | Level 3 claims group-0 interrupts |
| sreg_en_l1 | input | 1 | System-register interface enable, level 1 |
| sreg_en_l2 | input | 1 | System-register interface enable, level 2 |
| sreg_en_l3 | input | 1 | System-register interface enable, level 3 |
| hyp_trap_g0 | input | 1 | Hypervisor traps all group-0 accesses |
| hyp_fiq_route | input | 1 | Hypervisor routes group-0 interrupts to the virtual interface |
| rsp_valid | output | 1 | Verdict valid pulse |
| rsp_outcome | output | 4 | One-hot verdict |
| rsp_tgt_lvl | output | 2 | Trap target level |
| rsp_class | output | 6 | Trap syndrome class |

## Verification
On every cycle the assertions check several properties. The verdict is one-hot whenever valid, and the class and target fields agree with a trap. A valid pulse only follows a sampled request, and a mismatched encoding never yields one. A level-0 write always comes out UNDEF, a level-3 write with its enable clear traps to level 3, and VIRTUAL only ever follows a level-1 request. The bench scenarios are needed for the full priority chains at levels 1 and 2, which condition masks the next at each step, the level-2 on/off gating and the ignored hypervisor bits at level 2; these depend on combinations that a single property does not cover.

// File: rtl/sreg_trap_pkg.sv
// Shared types and constants for the group-0 end-of-interrupt write router.
// Assumes a 2-bit exception level and a 6-bit syndrome class field.
package sreg_trap_pkg;
    localparam int LVL_W   = 2;
    localparam int CLS_W   = 6;
    localparam int OC_W    = 4;
    localparam logic [CLS_W-1:0] TRAP_CLASS = 6'h18;

    typedef enum logic [OC_W-1:0] {
        OC_NONE  = 4'b0000,
        OC_UNDEF = 4'b0001,
        OC_TRAP  = 4'b0010,
        OC_VIRT  = 4'b0100,
        OC_PHYS  = 4'b1000
    } outcome_e;

    typedef struct packed {
        logic l2_impl;
        logic l2_sec_en;
        logic l3_impl;
        logic l3_undef_early;
        logic l3_undef_late;
        logic l3_fiq_route;
        logic sreg_en_l1;
        logic sreg_en_l2;
        logic sreg_en_l3;
        logic hyp_trap_g0;
        logic hyp_fiq_route;
    } ctl_t;

    typedef struct packed {
        outcome_e         oc;
        logic [LVL_W-1:0] tgt;
        logic [CLS_W-1:0] cls;
    } verdict_t;
endpackage

// File: rtl/sreg_enc_match.sv
// Compares a system-register encoding against the one this router serves.
// Assumes the five fields arrive together; purely combinational.
module sreg_enc_match #(
    parameter int          OP0_W = 2,
    parameter int          OP1_W = 3,
    parameter int          CRN_W = 4,
    parameter int          CRM_W = 4,
    parameter int          OP2_W = 3,
    parameter logic [1:0]  K_OP0 = 2'b11,
    parameter logic [2:0]  K_OP1 = 3'b000,
    parameter logic [3:0]  K_CRN = 4'b1100,
    parameter logic [3:0]  K_CRM = 4'b1000,
    parameter logic [2:0]  K_OP2 = 3'b001
) (
    input  logic [OP0_W-1:0] op0,
    input  logic [OP1_W-1:0] op1,
    input  logic [CRN_W-1:0] crn,
    input  logic [CRM_W-1:0] crm,
    input  logic [OP2_W-1:0] op2,
    output logic             hit
);
    localparam int NFIELD = 5;
    logic [NFIELD-1:0] fld_eq;

    // Per-field equality against the served encoding.
    always_comb begin
        fld_eq[0] = (op0 == K_OP0);
        fld_eq[1] = (op1 == K_OP1);
        fld_eq[2] = (crn == K_CRN);
        fld_eq[3] = (crm == K_CRM);
        fld_eq[4] = (op2 == K_OP2);
    end

    // The register is selected only when every field agrees.
    assign hit = &fld_eq;
endmodule

// File: rtl/sreg_trap_decide.sv
// Priority decision for one write: maps level and control bits to a verdict.
// Assumes the encoding has already been matched; purely combinational.
module sreg_trap_decide
    import sreg_trap_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    input  ctl_t             ctl,
    output verdict_t         verdict
);
    logic l2_on;
    logic undef_first;
    logic l3_claims;

    function automatic verdict_t mk_trap(input logic [LVL_W-1:0] t);
        verdict_t v;
        v.oc  = OC_TRAP;
        v.tgt = t;
        v.cls = TRAP_CLASS;
        return v;
    endfunction

    function automatic verdict_t mk_plain(input outcome_e o);
        verdict_t v;
        v.oc  = o;
        v.tgt = '0;
        v.cls = '0;
        return v;
    endfunction

    // Shared conditions used by more than one level's chain.
    always_comb begin
        l2_on       = ctl.l2_impl & ctl.l2_sec_en;
        undef_first = ctl.l3_impl & ctl.l3_undef_early & ctl.l3_fiq_route;
        l3_claims   = ctl.l3_impl & ctl.l3_fiq_route;
    end

    // Per-level ordered check chain; the first condition that applies wins.
    always_comb begin
        verdict = mk_plain(OC_PHYS);
        case (lvl)
            2'd0: verdict = mk_plain(OC_UNDEF);
            2'd1: begin
                if (undef_first)                       verdict = mk_plain(OC_UNDEF);
                else if (!ctl.sreg_en_l1)              verdict = mk_trap(2'd1);
                else if (l2_on && ctl.hyp_trap_g0)     verdict = mk_trap(2'd2);
                else if (l2_on && ctl.hyp_fiq_route)   verdict = mk_plain(OC_VIRT);
                else if (l3_claims)
                    verdict = ctl.l3_undef_late ? mk_plain(OC_UNDEF) : mk_trap(2'd3);
                else                                   verdict = mk_plain(OC_PHYS);
            end
            2'd2: begin
                if (undef_first)                       verdict = mk_plain(OC_UNDEF);
                else if (!ctl.sreg_en_l2)              verdict = mk_trap(2'd2);
                else if (l3_claims)
                    verdict = ctl.l3_undef_late ? mk_plain(OC_UNDEF) : mk_trap(2'd3);
                else                                   verdict = mk_plain(OC_PHYS);
            end
            default: begin
                if (!ctl.sreg_en_l3)                   verdict = mk_trap(2'd3);
                else                                   verdict = mk_plain(OC_PHYS);
            end
        endcase
    end
endmodule

// File: rtl/sreg_trap_outreg.sv
// Output stage: registers the verdict and raises a one-cycle valid pulse.
// Assumes in_fire is already qualified by an encoding match.
module sreg_trap_outreg
    import sreg_trap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_fire,
    input  verdict_t in_verdict,
    output logic     out_valid,
    output verdict_t out_verdict
);
    // Valid pulse follows each accepted request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_fire;
    end

    // Verdict is captured on an accepted request and held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_verdict <= '0;
        else if (in_fire) out_verdict <= in_verdict;
    end

    a_r10_onehot_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_verdict.oc) == 1));

    a_r6_trap_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_verdict.oc == OC_TRAP) |->
            (out_verdict.cls == TRAP_CLASS && out_verdict.tgt != '0));

    a_r6_quiet_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_verdict.oc != OC_TRAP) |->
            (out_verdict.cls == '0 && out_verdict.tgt == '0));

    a_r8_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_fire));
endmodule

// File: rtl/sreg_trap_router.sv
// Top: routes a write of the group-0 end-of-interrupt register to UNDEF, a trap,
// the virtual interface or the physical register. Assumes one request per strobe.
module sreg_trap_router
    import sreg_trap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_lvl,
    input  logic [1:0]       req_op0,
    input  logic [2:0]       req_op1,
    input  logic [3:0]       req_crn,
    input  logic [3:0]       req_crm,
    input  logic [2:0]       req_op2,
    input  logic             l2_impl,
    input  logic             l2_sec_en,
    input  logic             l3_impl,
    input  logic             l3_undef_early,
    input  logic             l3_undef_late,
    input  logic             l3_fiq_route,
    input  logic             sreg_en_l1,
    input  logic             sreg_en_l2,
    input  logic             sreg_en_l3,
    input  logic             hyp_trap_g0,
    input  logic             hyp_fiq_route,
    output logic             rsp_valid,
    output logic [OC_W-1:0]  rsp_outcome,
    output logic [LVL_W-1:0] rsp_tgt_lvl,
    output logic [CLS_W-1:0] rsp_class
);
    logic     enc_hit;
    logic     fire;
    ctl_t     ctl;
    verdict_t dec_v;
    verdict_t reg_v;

    sreg_enc_match u_match (
        .op0 (req_op0),
        .op1 (req_op1),
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .hit (enc_hit)
    );

    // Gather the control inputs into one bundle for the decision logic.
    always_comb begin
        ctl.l2_impl        = l2_impl;
        ctl.l2_sec_en      = l2_sec_en;
        ctl.l3_impl        = l3_impl;
        ctl.l3_undef_early = l3_undef_early;
        ctl.l3_undef_late  = l3_undef_late;
        ctl.l3_fiq_route   = l3_fiq_route;
        ctl.sreg_en_l1     = sreg_en_l1;
        ctl.sreg_en_l2     = sreg_en_l2;
        ctl.sreg_en_l3     = sreg_en_l3;
        ctl.hyp_trap_g0    = hyp_trap_g0;
        ctl.hyp_fiq_route  = hyp_fiq_route;
    end

    sreg_trap_decide u_decide (
        .lvl     (req_lvl),
        .ctl     (ctl),
        .verdict (dec_v)
    );

    assign fire = req_valid & enc_hit;

    sreg_trap_outreg u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_fire     (fire),
        .in_verdict  (dec_v),
        .out_valid   (rsp_valid),
        .out_verdict (reg_v)
    );

    assign rsp_outcome = reg_v.oc;
    assign rsp_tgt_lvl = reg_v.tgt;
    assign rsp_class   = reg_v.cls;

    a_r7_mismatch_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !enc_hit) |=> !rsp_valid);

    a_r1_level0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_lvl == 2'd0) |=> (rsp_valid && rsp_outcome == OC_UNDEF));

    a_r5_level3_disabled_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_lvl == 2'd3 && !sreg_en_l3) |=>
            (rsp_outcome == OC_TRAP && rsp_tgt_lvl == 2'd3));

    a_r2_virtual_from_level1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome == OC_VIRT) |-> ($past(req_lvl) == 2'd1));
endmodule

// File: tb/sreg_trap_router_tb.sv
module sreg_trap_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;
    // Entry: {lvl[2], l2i,l2s,l3i,early,late,route,en1,en2,en3,htrap,hroute, oc[4], tgt[2]}
    localparam logic [18:0] VEC [NVEC] = '{
        {2'd0, 11'b11111111111, 4'b0001, 2'd0},
        {2'd1, 11'b00110101100, 4'b0001, 2'd0},
        {2'd1, 11'b00010101100, 4'b0010, 2'd1},
        {2'd1, 11'b11000011111, 4'b0010, 2'd2},
        {2'd1, 11'b11100111101, 4'b0100, 2'd0},
        {2'd1, 11'b10000011111, 4'b1000, 2'd0},
        {2'd1, 11'b01000011111, 4'b1000, 2'd0},
        {2'd1, 11'b00101111111, 4'b0001, 2'd0},
        {2'd1, 11'b00100111111, 4'b0010, 2'd3},
        {2'd1, 11'b00111011100, 4'b1000, 2'd0},
        {2'd1, 11'b11000001111, 4'b0010, 2'd1},
        {2'd2, 11'b00110110100, 4'b0001, 2'd0},
        {2'd2, 11'b00100110100, 4'b0010, 2'd2},
        {2'd2, 11'b11100111111, 4'b0010, 2'd3},
        {2'd2, 11'b11101111111, 4'b0001, 2'd0},
        {2'd2, 11'b11011111111, 4'b1000, 2'd0},
        {2'd3, 11'b11111111011, 4'b0010, 2'd3},
        {2'd3, 11'b11111111111, 4'b1000, 2'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_lvl = '0;
    logic [1:0] req_op0 = 2'b11;
    logic [2:0] req_op1 = 3'b000;
    logic [3:0] req_crn = 4'b1100;
    logic [3:0] req_crm = 4'b1000;
    logic [2:0] req_op2 = 3'b001;
    logic [10:0] ctl_bits = '0;
    logic       rsp_valid;
    logic [3:0] rsp_outcome;
    logic [1:0] rsp_tgt_lvl;
    logic [5:0] rsp_class;
    int         n_chk = 0;
    int         n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sreg_trap_router dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lvl(req_lvl),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn),
        .req_crm(req_crm), .req_op2(req_op2),
        .l2_impl(ctl_bits[10]), .l2_sec_en(ctl_bits[9]), .l3_impl(ctl_bits[8]),
        .l3_undef_early(ctl_bits[7]), .l3_undef_late(ctl_bits[6]),
        .l3_fiq_route(ctl_bits[5]), .sreg_en_l1(ctl_bits[4]),
        .sreg_en_l2(ctl_bits[3]), .sreg_en_l3(ctl_bits[2]),
        .hyp_trap_g0(ctl_bits[1]), .hyp_fiq_route(ctl_bits[0]),
        .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome),
        .rsp_tgt_lvl(rsp_tgt_lvl), .rsp_class(rsp_class)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string lvl_tag(input logic [1:0] l);
        case (l)
            2'd0:    return "R1";
            2'd1:    return "R2";
            2'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    // Drive one request at a falling edge; return at the next falling edge.
    task automatic send(input logic [1:0] l, input logic [10:0] c);
        req_lvl   = l;
        ctl_bits  = c;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(rsp_valid == 1'b0, "R9", "valid", rsp_valid, 0);
        check(rsp_outcome == 4'b0 && rsp_tgt_lvl == 2'b0 && rsp_class == 6'b0,
              "R9", "fields", {rsp_outcome, rsp_tgt_lvl, rsp_class}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2, R3, R4, R5, R1, with R6 and R10 on each verdict.
        for (int i = 0; i < NVEC; i++) begin
            logic [3:0] e_oc;
            logic [1:0] e_tgt;
            logic [5:0] e_cls;
            e_oc  = VEC[i][5:2];
            e_tgt = VEC[i][1:0];
            e_cls = (e_oc == 4'b0010) ? 6'h18 : 6'h00;
            send(VEC[i][18:17], VEC[i][16:6]);
            check(rsp_valid == 1'b1, "R8", $sformatf("vec %0d valid", i), rsp_valid, 1);
            check(rsp_outcome == e_oc, lvl_tag(VEC[i][18:17]),
                  $sformatf("vec %0d outcome (R10 bits, R3 gating)", i), rsp_outcome, e_oc);
            check(rsp_tgt_lvl == e_tgt, "R6", $sformatf("vec %0d target", i), rsp_tgt_lvl, e_tgt);
            check(rsp_class == e_cls, "R6", $sformatf("vec %0d class", i), rsp_class, e_cls);
        end

        // R8: pulse lasts one cycle when no new request follows.
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8", "pulse width", rsp_valid, 0);

        // R7: flip one encoding field at a time; no valid pulse may appear.
        for (int f = 0; f < 5; f++) begin
            case (f)
                0: req_op0 = 2'b10;
                1: req_op1 = 3'b001;
                2: req_crn = 4'b1101;
                3: req_crm = 4'b1001;
                default: req_op2 = 3'b000;
            endcase
            send(2'd0, 11'b11111111111);
            check(rsp_valid == 1'b0, "R7", $sformatf("field %0d mismatch", f), rsp_valid, 0);
            req_op0 = 2'b11; req_op1 = 3'b000; req_crn = 4'b1100;
            req_crm = 4'b1000; req_op2 = 3'b001;
        end

        // R8: back-to-back requests give two consecutive valid verdicts.
        req_lvl = 2'd3; ctl_bits = 11'b00000000000; req_valid = 1'b1;
        @(negedge clk);
        check(rsp_valid && rsp_outcome == 4'b0010 && rsp_tgt_lvl == 2'd3, "R5",
              "first of pair", {rsp_valid, rsp_outcome, rsp_tgt_lvl}, 7'b1001011);
        req_lvl = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid && rsp_outcome == 4'b0001, "R1", "second of pair",
              {rsp_valid, rsp_outcome}, 5'b10001);

        // R9: reset in mid-operation clears a held verdict.
        send(2'd3, 11'b00000000100);
        rst_n = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0 && rsp_outcome == 4'b0, "R9", "reset clears",
              {rsp_valid, rsp_outcome}, 0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule